// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master end of a two-wire management link to PHY devices. Software sets up one transaction through a pair of 32-bit registers. The command register holds the start pattern, the opcode, the PHY address and the register address. The data register holds outgoing write data in its low half and the most recent read result in its high half. Writing the command register with its go bit set launches one frame. The block then generates the management clock MDC from the system clock and shifts the whole 64-bit frame out most-significant bit first. For a read it releases the data line and collects the 16 bits the PHY returns. The go bit reads back as a busy flag until the frame is over.

Inside, a state machine walks the frame with states ST_IDLE, ST_PRE (32 preamble ones), ST_ADDR (start, opcode, PHY address, register address), ST_TURN (2 turnaround bits) and ST_DATA (16 data bits). The transitions are these:
- launch: ST_IDLE to ST_PRE.
- preamble done: ST_PRE to ST_ADDR, at the MDC falling edge that ends bit 31.
- address done: ST_ADDR to ST_TURN, after bit 45.
- turnaround done: ST_TURN to ST_DATA, after bit 47.
- frame done: ST_DATA to ST_IDLE, after bit 63.

A divider produces MDC with a half period of MDC_HALF system clocks. The line changes on the falling edge of MDC and is sampled on the rising edge.

Top module: `mdio_master`

## Requirements
- R1: A frame is 64 bits sent MSB first. Frame bit 0 is the first bit on the line. The bits are, in order: bits 0..31 all ones, then start (2), opcode (2), PHY address (5), register address (5), turnaround (2) and data (16).
- R2: Each launch produces exactly 64 MDC rising edges. MDC then stays low until the next launch.
- R3: Bit 20 of the command register (select 0) reads 1 from the launch until the frame completes. It clears by itself no more than MDC_HALF+1 system clocks after the 64th MDC rising edge. A command write with bit 20 set while the block is idle launches one frame.
- R4: The command register layout is: register address in bits 4:0, PHY address in bits 9:5, opcode in bits 11:10, start in bits 13:12. Other bits read 0, apart from bit 20. The start and opcode sent on the line are exactly the stored values, whatever they are.
- R5: For any opcode other than 10 (binary), the turnaround is driven as 10 (binary) and the data bits come from data register bits 15:0. MDIO output enable stays high for all 64 bits.
- R6: For opcode 10 (a read), output enable is high for bits 0..45 and low for bits 46..63. The 16 bits sampled on MDC rising edges in bits 48..63 are stored MSB first into data register bits 31:16.
- R7: Data register bits 31:16 change only when a read frame completes. Write frames leave them unchanged. Software writes to bits 31:16 have no effect. Bits 15:0 keep the software value and are not sent during a read.
- R8: A command register write while busy is ignored. The stored fields are unchanged and no second frame is started.
- R9: MDC has a period of 2*MDC_HALF system clocks, with the first rising edge MDC_HALF clocks after launch. MDIO changes only on MDC falling edges while a frame is running.
- R10: After reset both registers read 0, MDC is low and output enable is low (the line is released to its idle-high level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command, 1 data |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 1 | Read source: 0 command, 1 data |
| rd_data | output | 32 | Register read value (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
A wrong state or bit count would show on the very next MDC rising edge. The symptom is a misplaced field on mdio_o or an output enable that flips at the wrong bit. A count that runs long or short shows in the number of MDC pulses, and in the busy flag clearing early or late within one MDC period. A fault in read capture or in command locking only shows when software reads the registers after the frame, so every frame ends with a register readback. Every PHY address and a spread of data words are swept across alternating reads and writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int PRE_LAST   = 31;
    localparam int ADDR_LAST  = 45;
    localparam int TURN_LAST  = 47;
    localparam int TURN_FIRST = 46;
    localparam int DATA_BITS  = 16;
    localparam int GO_BIT     = 20;
    localparam int CMD_BITS   = 14;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ADDR,
        ST_TURN,
        ST_DATA
    } seq_state_t;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise_tick = en && term && !mdc;
    assign fall_tick = en && term && mdc;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  is_read,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  done,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [DATA_BITS-1:0]  rx_data
);
    seq_state_t            state, nxt;
    logic [CNT_W-1:0]      bitcnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  rd_q;
    logic [CNT_W:0]        rise_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = ST_IDLE;
            ST_PRE:  nxt = (bitcnt == CNT_W'(PRE_LAST))  ? ST_ADDR : ST_PRE;
            ST_ADDR: nxt = (bitcnt == CNT_W'(ADDR_LAST)) ? ST_TURN : ST_ADDR;
            ST_TURN: nxt = (bitcnt == CNT_W'(TURN_LAST)) ? ST_DATA : ST_TURN;
            ST_DATA: nxt = (bitcnt == CNT_W'(FRAME_BITS - 1)) ? ST_IDLE : ST_DATA;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '1;
            rd_q     <= 1'b0;
            rx_data  <= '0;
            rise_cnt <= '0;
        end else if (launch && state == ST_IDLE) begin
            state    <= ST_PRE;
            bitcnt   <= '0;
            shreg    <= frame_in;
            rd_q     <= is_read;
            rise_cnt <= '0;
        end else begin
            if (fall_tick && state != ST_IDLE) begin
                state  <= nxt;
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
            end
            if (rise_tick && state != ST_IDLE)
                rise_cnt <= rise_cnt + 1'b1;
            if (rise_tick && state == ST_DATA)
                rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = fall_tick && (state == ST_DATA) && (bitcnt == CNT_W'(FRAME_BITS - 1));

    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_PRE, ST_ADDR: begin
                mdio_o  = shreg[FRAME_BITS-1];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = rd_q ? 1'b1 : shreg[FRAME_BITS-1];
                mdio_oe = !rd_q;
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

    // R2: a frame ends only after 64 MDC rising edges
    a_r2_sixty_four_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rise_cnt == (CNT_W+1)'(FRAME_BITS)));

    // R6: read frames release the line from turnaround onwards
    a_r6_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_q && bitcnt >= CNT_W'(TURN_FIRST)) |-> !mdio_oe);

    // R9: within a frame the line moves only on an MDC falling edge
    a_r9_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mdio_o != $past(mdio_o)) |-> $past(fall_tick));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [CMD_BITS-1:0]   cmd_q;
    logic [DATA_BITS-1:0]  wdat_q;
    logic [DATA_BITS-1:0]  rdat_q;
    logic                  rd_frame_q;
    logic                  busy, done, launch, rise_tick, fall_tick, rd_op;
    logic [DATA_BITS-1:0]  rx_data;
    logic [FRAME_BITS-1:0] frame;

    assign launch = wr_en && !wr_sel && wr_data[GO_BIT] && !busy;
    assign rd_op  = (wr_data[11:10] == OP_READ);
    assign frame  = {{(FRAME_BITS-CMD_BITS-2-DATA_BITS){1'b1}},
                     wr_data[13:12], wr_data[11:10], wr_data[9:5], wr_data[4:0],
                     (rd_op ? 2'b11 : 2'b10), wdat_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            wdat_q     <= '0;
            rdat_q     <= '0;
            rd_frame_q <= 1'b0;
        end else begin
            if (wr_en && !wr_sel && !busy)
                cmd_q <= wr_data[CMD_BITS-1:0];
            if (wr_en && wr_sel)
                wdat_q <= wr_data[DATA_BITS-1:0];
            if (launch)
                rd_frame_q <= rd_op;
            if (done && rd_frame_q)
                rdat_q <= rx_data;
        end
    end

    assign rd_data = rd_sel ? {rdat_q, wdat_q}
                            : {{(31-GO_BIT){1'b0}}, busy, {(GO_BIT-CMD_BITS){1'b0}}, cmd_q};

    mdio_clkdiv #(.HALF(MDC_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .frame_in  (frame),
        .is_read   (rd_op),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rx_data   (rx_data)
    );

    // R8: command fields frozen while a frame runs
    a_r8_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !wr_sel) |=> $stable(cmd_q));

    // R7: read field moves only at frame completion
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rdat_q));

    // R2: MDC rests low whenever no frame is running
    a_r2_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R3: the busy flag drops only on the completing edge
    a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rises = 0;
    logic [15:0] rdat_exp = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge mdc) rises <= rises + 1;

    mdio_master #(.MDC_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] resp,
                         input bit mid_write);
        logic [63:0] cap, oes, exp, emask, eoe;
        logic [31:0] cmdv, v;
        bit rd_frame;
        int r0, t0, t1, polls;
        rd_frame = (op == 2'b10);
        cmdv = {18'd0, st, op, phy, ra};
        exp = {32'hFFFF_FFFF, st, op, phy, ra, (rd_frame ? 2'b11 : 2'b10), wd};
        emask = rd_frame ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
        eoe = emask;
        cap = '0; oes = '0; t0 = 0; t1 = 0;
        wr(1'b1, {16'hDEAD, wd});
        r0 = rises;
        wr(1'b0, cmdv | 32'h0010_0000);
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            if (k == 0) t0 = cyc;
            if (k == 1) t1 = cyc;
            @(negedge clk);
            cap[63-k] = mdio_o;
            oes[63-k] = mdio_oe;
            if (k + 1 >= 48 && k + 1 < 64) mdio_i = resp[15-(k+1-48)];
            else mdio_i = 1'b1;
            if (mid_write && k == 10) wr(1'b0, 32'h0010_3FFF);
        end
        polls = 0;
        v = 32'h0010_0000;
        while (v[20] && polls < 20) begin
            rd(1'b0, v);
            polls++;
        end
        chk(!v[20] && polls <= HALF + 1, "R3 go bit self-clear", 64'(polls), 64'(HALF + 1));
        chk(v == cmdv, "R4/R8 command readback", 64'(v), 64'(cmdv));
        chk((cap & emask) == (exp & emask), "R1/R4/R5 frame bits", cap & emask, exp & emask);
        chk(oes == eoe, "R5/R6 output enable pattern", oes, eoe);
        chk(t1 - t0 == 2 * HALF, "R9 MDC period", 64'(t1 - t0), 64'(2 * HALF));
        repeat (4 * HALF) @(negedge clk);
        chk(rises - r0 == 64 && !mdc, "R2 exactly 64 MDC pulses", 64'(rises - r0), 64'd64);
        if (rd_frame) rdat_exp = resp;
        rd(1'b1, v);
        chk(v == {rdat_exp, wd}, "R6/R7 data register", 64'(v), 64'({rdat_exp, wd}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, v);
        chk(v == 0, "R10 command reg reset", 64'(v), 64'd0);
        rd(1'b1, v);
        chk(v == 0, "R10 data reg reset", 64'(v), 64'd0);
        chk(!mdc && !mdio_oe, "R10 MDC low, line released", {62'd0, mdc, mdio_oe}, 64'd0);
        // R7: software cannot write the read field
        wr(1'b1, 32'hFFFF_1234);
        rd(1'b1, v);
        chk(v == 32'h0000_1234, "R7 read field not writable", 64'(v), 64'h1234);
        // sweep every PHY address, alternating read and write
        for (int i = 0; i < 32; i++) begin
            logic [15:0] wd, rs;
            wd = 16'hA5C3 ^ 16'(i * 16'h1357);
            rs = ~wd ^ 16'(i << 3);
            frame(2'b01, (i % 2 == 1) ? 2'b10 : 2'b01, 5'(i), 5'(31 - i), wd, rs, 1'b0);
        end
        // R4: non-standard start and opcode are sent as stored
        frame(2'b11, 2'b00, 5'd7, 5'd21, 16'h8001, 16'h0, 1'b0);
        frame(2'b00, 2'b11, 5'd30, 5'd1, 16'h7FFE, 16'h0, 1'b0);
        // R8: command write during a running frame is ignored
        frame(2'b01, 2'b10, 5'd9, 5'd18, 16'h0F0F, 16'hC33C, 1'b1);
        frame(2'b01, 2'b01, 5'd17, 5'd4, 16'hFFFF, 16'h0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule